// File: doc/BRIEF.md
# Fault-Class Read Steering for Replicated Words

This block sits in the read path of a memory controller. Each 64-bit word in memory is stored as a (72,64) SECDED codeword. A word may have a hard fault found by an earlier memory test. Every word is sorted into one of three fault classes: clean, single-bit hard fault, or multi-bit hard fault. For each read request the block looks up the word's class and decides which copy to read. A clean word is read only at its primary location. A word with one hard fault is read at its primary location, and its replica is read only when that primary read reports an uncorrectable error. A word with a multi-bit fault is retired, so it is read only from its replica. The replica lives in a reserved area at a configurable base address.

The classes come from a fault map held in memory. A small on-chip cache keeps part of that map. The cache is direct-mapped with 16 entries, and each entry holds 2-bit classes for 32 consecutive words. When a lookup misses, the request stalls. The block raises a fill request naming the map line it needs and resumes once that line is written in. The SECDED decoder is outside the block: every returned memory word arrives with an uncorrectable flag. The response carries the chosen data and an error flag.

Top module: `fmap_steer`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1 and `rsp_valid`, `rd_valid` and `fill_req_valid` are 0. No map line is cached, so the first request after reset raises a fill request.
- R2: A map line is word index >> 5, and the cache set is line mod 16. On a miss, `fill_req_valid` rises with `fill_req_line` set to the request's line. Both hold until a fill write of that same line arrives, and the request then continues. On a hit, no fill request is raised. `fill_req_valid` and `rd_valid` are never high together.
- R3: In a map line written on `fill_wr_bits`, the class of the word at offset k (word index mod 32) sits in bits [2k+1:2k]. The encoding is 00 = clean, 01 = single-bit fault, 10 = multi-bit fault, and 11 = reserved, which is handled as multi-bit.
- R4: For a clean word, exactly one read is issued, at the primary address, which is the word index. The response returns that data, and `rsp_err` equals that read's uncorrectable flag. No replica read is issued, even when the flag is set.
- R5: For a single-bit-fault word, the primary address is read first. If that read is not uncorrectable, the block responds with its data and `rsp_err` = 0, and no replica read is issued. If it is uncorrectable, a replica read follows and the block responds with the replica's data. `rsp_err` is then 1 only if the replica is also uncorrectable.
- R6: For a multi-bit-fault or reserved word, only the replica is read. `rsp_err` equals the replica's uncorrectable flag.
- R7: The replica address is `repl_base` + word index, kept to ADDR_W bits, so the sum wraps around.
- R8: At most one memory read is outstanding. `rd_valid` and `rd_addr` hold steady until `rd_ready`. Each accepted request gets exactly one single-cycle `rsp_valid` pulse. `req_ready` is 1 only while no request is in progress.
- R9: Filling a line into a set replaces the line held there before. A later request to the replaced line misses and raises a new fill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_base | input | ADDR_W | Base word index of the replication area |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Requested word index |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_data | output | DATA_W | Response data |
| rsp_err | output | 1 | Every consulted copy was uncorrectable |
| rd_valid | output | 1 | Memory read issue |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Word index to read |
| rd_ret_valid | input | 1 | Read data returned |
| rd_ret_data | input | DATA_W | Returned (decoded) data |
| rd_ret_uncorr | input | 1 | Decoder reported an uncorrectable error |
| fill_req_valid | output | 1 | Fault-map line needed |
| fill_req_line | output | ADDR_W-5 | Index of the needed map line |
| fill_wr_valid | input | 1 | Map line write strobe |
| fill_wr_line | input | ADDR_W-5 | Index of the written map line |
| fill_wr_bits | input | 64 | Classes of the 32 words in the line |

## Verification
Words of every class are read, including the reserved code, and each is tried with primary and replica uncorrectable flags set in turn. This shows that the flag of a copy the block should ignore does not change the outcome, and that a replica read happens only where the class calls for one. Repeated reads in one line, a second line in the same set, and a return to the first line together separate a cache hit from a miss and an eviction. Reads at the last offset of a line check the class field position. Changing the replica base, including a value that makes the sum wrap, checks the replica address arithmetic.

// File: rtl/fmap_pkg.sv
package fmap_pkg;
  typedef enum logic [1:0] {
    FC_CLEAN = 2'b00,
    FC_ONE   = 2'b01,
    FC_MULTI = 2'b10,
    FC_RSVD  = 2'b11
  } fclass_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_CHK, S_FILL, S_ISSUE, S_WAIT
  } steer_state_e;

  // Only the upper class bit is needed: 10 and 11 both retire the primary copy.
  function automatic logic replica_only(fclass_e c);
    return c[1];
  endfunction
endpackage

// File: rtl/fmap_cache.sv
module fmap_cache #(
  parameter int ADDR_W     = 20,
  parameter int LINE_WORDS = 32,
  parameter int SETS       = 16,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - SET_W,
  localparam int BITS_W = 2 * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [LINE_W-1:0] rd_line,
  output logic              hit,
  output logic [BITS_W-1:0] rd_bits,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [BITS_W-1:0] wr_bits
);
  logic [BITS_W-1:0] line_ram [SETS];
  logic [TAG_W-1:0]  tag_ram  [SETS];
  logic [SETS-1:0]   vld;

  logic [SET_W-1:0] rd_set, wr_set;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_set = rd_line[SET_W-1:0];
  assign rd_tag = rd_line[LINE_W-1:SET_W];
  assign wr_set = wr_line[SET_W-1:0];
  assign wr_tag = wr_line[LINE_W-1:SET_W];

  // Class storage: plain synchronous RAM with a registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) line_ram[wr_set] <= wr_bits;
    if (rd_en) rd_bits <= line_ram[rd_set];
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_ram[wr_set] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      hit <= 1'b0;
    end else begin
      if (wr_en) vld[wr_set] <= 1'b1;
      if (rd_en) hit <= vld[rd_set] && (tag_ram[rd_set] == rd_tag);
    end
  end
endmodule

// File: rtl/fmap_word_sel.sv
module fmap_word_sel
  import fmap_pkg::*;
#(
  parameter int LINE_WORDS = 32,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int BITS_W = 2 * LINE_WORDS
) (
  input  logic [BITS_W-1:0] line_bits,
  input  logic [OFF_W-1:0]  off,
  output fclass_e           cls
);
  logic [1:0] fields [LINE_WORDS];

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_field
    assign fields[k] = line_bits[2*k +: 2];
  end

  assign cls = fclass_e'(fields[off]);
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import fmap_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 5,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] repl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ret_valid,
  input  logic [DATA_W-1:0] rd_ret_data,
  input  logic              rd_ret_uncorr,
  output logic              fill_req_valid,
  output logic [LINE_W-1:0] fill_req_line,
  input  logic              fill_wr_valid,
  input  logic [LINE_W-1:0] fill_wr_line,
  output logic              map_rd_en,
  output logic [LINE_W-1:0] map_line,
  output logic [OFF_W-1:0]  map_off,
  input  logic              map_hit,
  input  fclass_e           map_cls
);
  steer_state_e      state;
  logic [ADDR_W-1:0] addr_q, rep_q;
  fclass_e           cls_q;
  logic              use_rep_q;

  assign req_ready      = (state == S_IDLE);
  assign rd_valid       = (state == S_ISSUE);
  assign rd_addr        = use_rep_q ? rep_q : addr_q;
  assign fill_req_valid = (state == S_FILL);
  assign map_line       = addr_q[ADDR_W-1:OFF_W];
  assign fill_req_line  = map_line;
  assign map_off        = addr_q[OFF_W-1:0];
  assign map_rd_en      = (state == S_LOOK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      rep_q     <= '0;
      cls_q     <= FC_CLEAN;
      use_rep_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rep_q  <= repl_base + req_addr;
          state  <= S_LOOK;
        end
        S_LOOK: state <= S_CHK;
        S_CHK: if (!map_hit) begin
          state <= S_FILL;
        end else begin
          cls_q     <= map_cls;
          use_rep_q <= replica_only(map_cls);
          state     <= S_ISSUE;
        end
        S_FILL: if (fill_wr_valid && fill_wr_line == map_line) state <= S_LOOK;
        S_ISSUE: if (rd_ready) state <= S_WAIT;
        S_WAIT: if (rd_ret_valid) begin
          if (!use_rep_q && cls_q == FC_ONE && rd_ret_uncorr) begin
            use_rep_q <= 1'b1;
            state     <= S_ISSUE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_ret_data;
            rsp_err   <= rd_ret_uncorr;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fmap_steer.sv
module fmap_steer
  import fmap_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int LINE_WORDS = 32,
  parameter int SETS       = 16,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int BITS_W = 2 * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] repl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ret_valid,
  input  logic [DATA_W-1:0] rd_ret_data,
  input  logic              rd_ret_uncorr,
  output logic              fill_req_valid,
  output logic [LINE_W-1:0] fill_req_line,
  input  logic              fill_wr_valid,
  input  logic [LINE_W-1:0] fill_wr_line,
  input  logic [BITS_W-1:0] fill_wr_bits
);
  logic              map_rd_en, map_hit;
  logic [LINE_W-1:0] map_line;
  logic [OFF_W-1:0]  map_off;
  logic [BITS_W-1:0] map_bits;
  fclass_e           map_cls;

  fmap_cache #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)) u_cache (
    .clk(clk), .rst(rst),
    .rd_en(map_rd_en), .rd_line(map_line), .hit(map_hit), .rd_bits(map_bits),
    .wr_en(fill_wr_valid), .wr_line(fill_wr_line), .wr_bits(fill_wr_bits)
  );

  fmap_word_sel #(.LINE_WORDS(LINE_WORDS)) u_sel (
    .line_bits(map_bits), .off(map_off), .cls(map_cls)
  );

  steer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .repl_base(repl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_ret_valid(rd_ret_valid), .rd_ret_data(rd_ret_data), .rd_ret_uncorr(rd_ret_uncorr),
    .fill_req_valid(fill_req_valid), .fill_req_line(fill_req_line),
    .fill_wr_valid(fill_wr_valid), .fill_wr_line(fill_wr_line),
    .map_rd_en(map_rd_en), .map_line(map_line), .map_off(map_off),
    .map_hit(map_hit), .map_cls(map_cls)
  );
endmodule

// File: rtl/fmap_steer_chk.sv
module fmap_steer_chk #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 5,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] repl_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              fill_req_valid,
  input logic [LINE_W-1:0] fill_req_line,
  input logic              fill_wr_valid,
  input logic [LINE_W-1:0] fill_wr_line
);
  logic [ADDR_W-1:0] acc_addr;

  always_ff @(posedge clk) begin
    if (rst) acc_addr <= '0;
    else if (req_valid && req_ready) acc_addr <= req_addr;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready && !rsp_valid); // R8
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid && !(fill_wr_valid && fill_wr_line == fill_req_line)
      |=> fill_req_valid && $stable(fill_req_line)); // R2
  AST_FILL_LINE: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> fill_req_line == acc_addr[ADDR_W-1:OFF_W]); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(fill_req_valid && rd_valid)); // R2
  AST_RD_TARGET: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_addr == acc_addr) || (rd_addr == ADDR_W'(acc_addr + repl_base))); // R7
endmodule

bind fmap_steer fmap_steer_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .repl_base(repl_base),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .fill_req_valid(fill_req_valid), .fill_req_line(fill_req_line),
  .fill_wr_valid(fill_wr_valid), .fill_wr_line(fill_wr_line)
);

// File: tb/sim_fmap_steer.sv
`timescale 1ns/1ps
module sim_fmap_steer;
  localparam int AW = 20;
  localparam int DW = 64;
  localparam int LW = AW - 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] repl_base = 20'h80000;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data;
  logic rd_valid;
  logic rd_ready = 1'b1;
  logic [AW-1:0] rd_addr;
  logic rd_ret_valid = 1'b0;
  logic [DW-1:0] rd_ret_data = '0;
  logic rd_ret_uncorr = 1'b0;
  logic fill_req_valid;
  logic [LW-1:0] fill_req_line;
  logic fill_wr_valid = 1'b0;
  logic [LW-1:0] fill_wr_line = '0;
  logic [63:0] fill_wr_bits = '0;

  fmap_steer u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, fills = 0;
  bit busy = 1'b0, done = 1'b0;
  logic [AW-1:0] reads [$];
  logic [AW-1:0] cur_pri;
  bit bad_pri, bad_rep, ret_pend = 1'b0;
  logic [AW-1:0] ret_addr;

  function automatic logic [1:0] cls_of(logic [AW-1:0] a);
    return a[1:0] ^ a[6:5];
  endfunction

  function automatic logic [63:0] map_bits(logic [LW-1:0] line);
    logic [63:0] b;
    for (int k = 0; k < 32; k++) b[2*k +: 2] = cls_of({line, 5'(k)});
    return b;
  endfunction

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] x);
    return {12'hABC, x, 12'h123, ~x};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  endtask

  // Memory and fill responder, plus a per-cycle protocol check.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
    if (!rst) begin
      if (ret_pend) begin
        rd_ret_valid  = 1'b1;
        rd_ret_data   = mem_word(ret_addr);
        rd_ret_uncorr = (ret_addr == cur_pri) ? bad_pri : bad_rep;
        ret_pend      = 1'b0;
      end else begin
        rd_ret_valid = 1'b0;
      end
      if (rd_valid && rd_ready) begin
        reads.push_back(rd_addr);
        ret_addr = rd_addr;
        ret_pend = 1'b1;
      end
      if (fill_wr_valid) begin
        fill_wr_valid = 1'b0;
      end else if (fill_req_valid) begin
        fill_wr_valid = 1'b1;
        fill_wr_line  = fill_req_line;
        fill_wr_bits  = map_bits(fill_req_line);
        fills++;
      end
      if (!busy && (rsp_valid || rd_valid || fill_req_valid)) begin
        total++; bad++;
        $display("FAIL R8 activity while idle actual=%b%b%b expected=000",
                 rsp_valid, rd_valid, fill_req_valid);
      end
    end
  end

  // Reference: the class picks the reads; the last read's data and flag form the response.
  task automatic do_read(string req, logic [AW-1:0] a, bit bp, bit br, int exp_fills);
    logic [AW-1:0] rep;
    logic [AW-1:0] exp_q [$];
    logic [1:0] c;
    bit got = 1'b0;
    bit exp_err;
    logic [DW-1:0] exp_data;
    rep = repl_base + a;
    c = cls_of(a);
    cur_pri = a; bad_pri = bp; bad_rep = br;
    if (c == 2'b00) begin
      exp_q.push_back(a); exp_err = bp; exp_data = mem_word(a);
    end else if (c == 2'b01) begin
      exp_q.push_back(a);
      if (bp) begin exp_q.push_back(rep); exp_err = br; exp_data = mem_word(rep); end
      else begin exp_err = 1'b0; exp_data = mem_word(a); end
    end else begin
      exp_q.push_back(rep); exp_err = br; exp_data = mem_word(rep);
    end
    reads.delete();
    fills = 0;
    busy = 1'b1;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (rsp_valid) begin
        got = 1'b1;
        check(req, "rsp_data", rsp_data, exp_data);
        check(req, "rsp_err", 64'(rsp_err), 64'(exp_err));
      end else begin
        @(negedge clk);
      end
    end
    check(req, "response seen", 64'(got), 64'd1);
    check(req, "fill count", 64'(fills), 64'(exp_fills));
    check(req, "read count", 64'(reads.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < reads.size(); i++)
      check(req, "read address", 64'(reads[i]), 64'(exp_q[i]));
    @(negedge clk);
    check(req, "single response pulse", 64'(rsp_valid), 64'd0);
    check(req, "ready after response", 64'(req_ready), 64'd1);
    busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "rd_valid", 64'(rd_valid), 64'd0);
    check("R1", "fill_req_valid", 64'(fill_req_valid), 64'd0);
    do_read("R1", 20'h00100, 1'b0, 1'b0, 1);       // clean, empty cache fills
    do_read("R4", 20'h00100, 1'b1, 1'b1, 0);       // clean, primary bad, no replica
    do_read("R2", 20'h00101, 1'b0, 1'b1, 0);       // hit; single-bit, primary good
    do_read("R5", 20'h00101, 1'b1, 1'b0, 0);       // single-bit, fall back to replica
    do_read("R5", 20'h00101, 1'b1, 1'b1, 0);       // both copies bad
    do_read("R6", 20'h00102, 1'b1, 1'b0, 0);       // multi-bit, replica only
    do_read("R6", 20'h00103, 1'b0, 1'b1, 0);       // reserved code, replica only
    do_read("R3", 20'h0015F, 1'b1, 1'b0, 1);       // offset 31 field, single-bit
    do_read("R9", 20'h00300, 1'b0, 1'b0, 1);       // same set, other line
    do_read("R9", 20'h00100, 1'b0, 1'b0, 1);       // evicted line refetched
    repl_base = 20'h40000;
    do_read("R7", 20'h00102, 1'b0, 1'b0, 0);       // new base
    repl_base = 20'hFFF00;
    do_read("R7", 20'h00102, 1'b0, 1'b0, 0);       // wrapping sum
    summary();
  end
endmodule